// File: doc/BRIEF.md
# Interlaken Receive Packet Error Monitor

This block is a passive observer on the receive user data interface of an Interlaken core in single-segment mode. It follows each packet from its opening cycle to its closing cycle and captures the destination channel when the packet opens. It adds up the packet's byte count, and when the packet closes it rules the packet good or errored. Counters for good packets, errored packets and CRC24 error events are kept side by side. The block drives nothing back into the datapath.

The CRC24 counter reads the real-time CRC24 status line on every clock. It does not use the per-packet error flag. Because of this, corruption on a link that carries only idle control words is still counted. A build-time parameter turns off advanced error reporting. In that build the per-packet error flag is ignored, and the CRC24 status line decides whether a packet is errored.

A two-state machine tracks packet framing. `ST_IDLE` means no packet is open. `ST_OPEN` means a packet has started and has not yet ended. The transitions are:

- IDLE to OPEN on a start without an end.
- IDLE to IDLE on a single-cycle packet (start and end together).
- IDLE to IDLE with a violation on an end with no start.
- OPEN to IDLE on an end.
- OPEN to OPEN with a violation and a restart on a start without an end.
- OPEN to IDLE with a violation on a start and an end together.

Top module: `ilk_rx_err_mon`

## Requirements
- R1: When a packet closes, it is good only if the effective error flag is low and the end code `rx_eop_code` is not 4'b0001. Otherwise it is errored. `good_cnt` or `err_cnt` rises by one accordingly, and `last_good` shows the verdict.
- R2: `crc_cnt` rises by one for every clock in which `crc24_err` is high. `rx_err` has no effect on it.
- R3: `crc_cnt` keeps counting while no packet is open and `rx_valid` is low.
- R4: With `ADV_ERR_EN` = 0, the effective error flag is `crc24_err` sampled at the closing cycle, and `rx_err` is ignored. With `ADV_ERR_EN` = 1, the effective error flag is `rx_err`.
- R5: A packet opens when `rx_valid` is high and `rx_sop_vec[1]` is high. The `rx_chan` value in that cycle is reported on `last_chan` when the packet closes.
- R6: A packet closes in a valid cycle whose `rx_eop_code` is nonzero. Each non-closing cycle adds `rx_nvalid`×8 bytes. The closing cycle adds (`rx_nvalid`−1)×8 plus the value of `rx_eop_code[2:0]`, where 3'b000 stands for 8. The total is reported on `last_bytes`; a 179-byte packet reports 179.
- R7: `done` pulses for one clock in the cycle after the closing edge. `last_chan`, `last_bytes` and `last_good` hold their values until the next packet closes.
- R8: `proto_err` pulses in the cycle after either of two events. The first is a start while a packet is open: the open packet is dropped without being counted, and the new one begins. The second is an end with no packet open: it produces no `done` and changes no count.
- R9: Every counter stops at its all-ones value and does not wrap.
- R10: `clr` sets all three counters to zero on the next edge and takes priority over any increment. Reset sets every output to zero.
- R11: Per-packet state starts fresh at each start. After an errored packet and idle cycles, the next packet's bytes, channel and verdict do not depend on the earlier packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous counter clear |
| rx_valid | input | 1 | Cycle carries packet data |
| rx_sop_vec | input | 2 | Start vector; bit 1 marks start of packet |
| rx_chan | input | CH_W | Channel number, meaningful at start |
| rx_nvalid | input | 4 | Valid 64-bit words this cycle (1..8) |
| rx_eop_code | input | 4 | 0 = not the end; nonzero = end; 4'b0001 = errored end; low 3 bits = bytes in last word |
| rx_err | input | 1 | Per-packet error flag |
| crc24_err | input | 1 | Real-time CRC24 error status |
| done | output | 1 | One-cycle packet-complete pulse |
| last_chan | output | CH_W | Channel of last completed packet |
| last_bytes | output | BYTE_W | Byte count of last completed packet |
| last_good | output | 1 | Verdict of last completed packet |
| proto_err | output | 1 | One-cycle framing violation pulse |
| good_cnt | output | CNT_W | Good packet counter |
| err_cnt | output | CNT_W | Errored packet counter |
| crc_cnt | output | CNT_W | CRC24 error event counter |

## Verification
Counter saturation is the hardest condition to reach from the ports. At 32 bits it would take billions of events, so the bench narrows `CNT_W` to 6. It then holds `crc24_err` high through a long idle stretch and sends a run of single-cycle packets, which drives both counters to their ceiling. The second hard case is a start arriving inside an open packet. The bench forces it by opening a packet and then sending a single-cycle packet on another channel before the first one ends. A second instance built with `ADV_ERR_EN` = 0 sees the same stimulus, so the two error sources can be told apart.

// File: rtl/ilk_mon_pkg.sv
package ilk_mon_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } mon_state_e;

    localparam logic [3:0] EOP_ABORT = 4'b0001;
    localparam int         WORD_BYTES = 8;
endpackage

// File: rtl/ilk_mon_satcnt.sv
module ilk_mon_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ilk_mon_fsm.sv
module ilk_mon_fsm
    import ilk_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sop,
    input  logic       eop,
    output mon_state_e state,
    output logic       finish,
    output logic       viol
);
    mon_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        finish   = 1'b0;
        viol     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sop && eop) begin
                    finish = 1'b1;
                end else if (sop) begin
                    state_nx = ST_OPEN;
                end else if (eop) begin
                    viol = 1'b1;
                end
            end
            ST_OPEN: begin
                if (sop) begin
                    viol = 1'b1;
                end
                if (eop) begin
                    finish   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ilk_rx_err_mon.sv
module ilk_rx_err_mon
    import ilk_mon_pkg::*;
#(
    parameter int CH_W       = 8,
    parameter int BYTE_W     = 16,
    parameter int CNT_W      = 32,
    parameter bit ADV_ERR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rx_valid,
    input  logic [1:0]        rx_sop_vec,
    input  logic [CH_W-1:0]   rx_chan,
    input  logic [3:0]        rx_nvalid,
    input  logic [3:0]        rx_eop_code,
    input  logic              rx_err,
    input  logic              crc24_err,
    output logic              done,
    output logic [CH_W-1:0]   last_chan,
    output logic [BYTE_W-1:0] last_bytes,
    output logic              last_good,
    output logic              proto_err,
    output logic [CNT_W-1:0]  good_cnt,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [CNT_W-1:0]  crc_cnt
);
    localparam int NCNT = 3;
    localparam logic [BYTE_W-1:0] WB = BYTE_W'(WORD_BYTES);

    logic              sop, eop;
    mon_state_e        state;
    logic              finish, viol;
    logic [BYTE_W-1:0] full_b, tail_b, cyc_b, pkt_total, acc_q;
    logic [CH_W-1:0]   chan_q;
    logic              err_eff, pkt_good;
    logic [NCNT-1:0]   inc_vec;
    logic [CNT_W-1:0]  cnt_arr [NCNT];

    assign sop = rx_valid && rx_sop_vec[1];
    assign eop = rx_valid && (rx_eop_code != 4'b0000);

    ilk_mon_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sop    (sop),
        .eop    (eop),
        .state  (state),
        .finish (finish),
        .viol   (viol)
    );

    // Byte arithmetic for the current cycle
    always_comb begin
        full_b = BYTE_W'(rx_nvalid) * WB;
        tail_b = (rx_eop_code[2:0] == 3'b000) ? WB : BYTE_W'(rx_eop_code[2:0]);
        cyc_b  = eop ? (full_b - WB + tail_b) : full_b;
        pkt_total = (sop ? '0 : acc_q) + cyc_b;
    end

    assign err_eff  = ADV_ERR_EN ? rx_err : crc24_err;
    assign pkt_good = !err_eff && (rx_eop_code != EOP_ABORT);

    // Per-packet state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            chan_q <= '0;
        end else begin
            if (sop || (rx_valid && state == ST_OPEN)) begin
                acc_q <= pkt_total;
            end
            if (sop) begin
                chan_q <= rx_chan;
            end
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            last_chan  <= '0;
            last_bytes <= '0;
            last_good  <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            done      <= finish;
            proto_err <= viol;
            if (finish) begin
                last_chan  <= sop ? rx_chan : chan_q;
                last_bytes <= pkt_total;
                last_good  <= pkt_good;
            end
        end
    end

    assign inc_vec[0] = finish && pkt_good;
    assign inc_vec[1] = finish && !pkt_good;
    assign inc_vec[2] = crc24_err;

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        ilk_mon_satcnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_vec[gi]),
            .cnt   (cnt_arr[gi])
        );
    end

    assign good_cnt = cnt_arr[0];
    assign err_cnt  = cnt_arr[1];
    assign crc_cnt  = cnt_arr[2];
endmodule

// File: rtl/ilk_rx_err_mon_chk.sv
module ilk_rx_err_mon_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             rx_valid,
    input logic [3:0]       rx_eop_code,
    input logic             crc24_err,
    input logic             done,
    input logic             last_good,
    input logic             proto_err,
    input logic [CNT_W-1:0] good_cnt,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] crc_cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_done_after_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rst_n) && $past(rx_valid) && ($past(rx_eop_code) != 4'b0000)));

    p_crc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(crc24_err) && !$past(clr) && ($past(crc_cnt) != TOP))
        |-> (crc_cnt == $past(crc_cnt) + 1'b1));

    p_crc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(crc24_err) && !$past(clr)) |-> (crc_cnt == $past(crc_cnt)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && ($past(good_cnt) == TOP)) |-> (good_cnt == TOP));

    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (good_cnt == '0 && err_cnt == '0 && crc_cnt == '0));

    p_good_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && (good_cnt != $past(good_cnt))) |-> (done && last_good));

    p_err_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && (err_cnt != $past(err_cnt))) |-> (done && !last_good));

    p_viol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> ($past(rst_n) && $past(rx_valid)));
endmodule

bind ilk_rx_err_mon ilk_rx_err_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .rx_valid    (rx_valid),
    .rx_eop_code (rx_eop_code),
    .crc24_err   (crc24_err),
    .done        (done),
    .last_good   (last_good),
    .proto_err   (proto_err),
    .good_cnt    (good_cnt),
    .err_cnt     (err_cnt),
    .crc_cnt     (crc_cnt)
);

// File: tb/ilk_rx_err_mon_tb.sv
`timescale 1ns/1ps
module ilk_rx_err_mon_tb;
    localparam int CW  = 6;
    localparam int MAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic rx_valid = 1'b0;
    logic [1:0] rx_sop_vec = 2'b00;
    logic [7:0] rx_chan = 8'h0;
    logic [3:0] rx_nvalid = 4'h0;
    logic [3:0] rx_eop_code = 4'h0;
    logic rx_err = 1'b0;
    logic crc24_err = 1'b0;

    logic done, last_good, proto_err, done2, last_good2, proto2;
    logic [7:0] last_chan, last_chan2;
    logic [15:0] last_bytes, last_bytes2;
    logic [CW-1:0] good_cnt, err_cnt, crc_cnt, good2, err2, crc2;

    always #2 clk = ~clk;

    ilk_rx_err_mon #(.CNT_W(CW), .ADV_ERR_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rx_valid(rx_valid), .rx_sop_vec(rx_sop_vec),
        .rx_chan(rx_chan), .rx_nvalid(rx_nvalid), .rx_eop_code(rx_eop_code), .rx_err(rx_err),
        .crc24_err(crc24_err), .done(done), .last_chan(last_chan), .last_bytes(last_bytes),
        .last_good(last_good), .proto_err(proto_err), .good_cnt(good_cnt), .err_cnt(err_cnt),
        .crc_cnt(crc_cnt));

    ilk_rx_err_mon #(.CNT_W(CW), .ADV_ERR_EN(1'b0)) u_dut_basic (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rx_valid(rx_valid), .rx_sop_vec(rx_sop_vec),
        .rx_chan(rx_chan), .rx_nvalid(rx_nvalid), .rx_eop_code(rx_eop_code), .rx_err(rx_err),
        .crc24_err(crc24_err), .done(done2), .last_chan(last_chan2), .last_bytes(last_bytes2),
        .last_good(last_good2), .proto_err(proto2), .good_cnt(good2), .err_cnt(err2),
        .crc_cnt(crc2));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_good, m_err, m_crc, m_good2, m_err2;
    int m_acc, m_chan;
    bit m_open;
    int e_chan, e_bytes;
    bit e_done, e_good, e_good2, e_proto;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_good = 0; m_err = 0; m_crc = 0; m_good2 = 0; m_err2 = 0;
            m_acc = 0; m_chan = 0; m_open = 0;
            e_chan = 0; e_bytes = 0; e_done = 0; e_good = 0; e_good2 = 0; e_proto = 0;
        end else begin
            int nb;
            bit is_sop, is_eop, g, g2;
            e_done = 0;
            e_proto = 0;
            if (clr) begin
                m_good = 0; m_err = 0; m_crc = 0; m_good2 = 0; m_err2 = 0;
            end else if (crc24_err && m_crc < MAX) begin
                m_crc++;
            end
            if (rx_valid) begin
                is_sop = rx_sop_vec[1];
                is_eop = (rx_eop_code != 0);
                nb = is_eop ? (int'(rx_nvalid) - 1) * 8 + ((rx_eop_code[2:0] == 0) ? 8 : int'(rx_eop_code[2:0]))
                            : int'(rx_nvalid) * 8;
                if (is_sop) begin
                    if (m_open) e_proto = 1;
                    m_acc = nb; m_chan = rx_chan; m_open = 1;
                end else if (m_open) begin
                    m_acc += nb;
                end else if (is_eop) begin
                    e_proto = 1;
                end
                if (is_eop && m_open) begin
                    g  = !rx_err && (rx_eop_code != 4'b0001);
                    g2 = !crc24_err && (rx_eop_code != 4'b0001);
                    e_done = 1; e_chan = m_chan; e_bytes = m_acc; e_good = g; e_good2 = g2;
                    if (!clr) begin
                        if (g) begin if (m_good < MAX) m_good++; end
                        else begin if (m_err < MAX) m_err++; end
                        if (g2) begin if (m_good2 < MAX) m_good2++; end
                        else begin if (m_err2 < MAX) m_err2++; end
                    end
                    m_open = 0;
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 done", int'(done), int'(e_done));
            chk("R5 last_chan", int'(last_chan), e_chan);
            chk("R6 last_bytes", int'(last_bytes), e_bytes);
            chk("R1 last_good", int'(last_good), int'(e_good));
            chk("R1 good_cnt", int'(good_cnt), m_good);
            chk("R1 err_cnt", int'(err_cnt), m_err);
            chk("R2 crc_cnt", int'(crc_cnt), m_crc);
            chk("R8 proto_err", int'(proto_err), int'(e_proto));
            chk("R4 good_cnt basic", int'(good2), m_good2);
            chk("R4 err_cnt basic", int'(err2), m_err2);
            chk("R4 last_good basic", int'(last_good2), int'(e_good2));
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle_in();
        rx_valid = 0; rx_sop_vec = 0; rx_nvalid = 0; rx_eop_code = 0; rx_err = 0;
    endtask

    task automatic send_pkt(input int ch, input int nbytes, input bit err, input bit abort);
        int words = (nbytes + 7) / 8;
        int ncyc = (words + 7) / 8;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            rx_valid = 1;
            rx_sop_vec = (i == 0) ? 2'b10 : 2'b00;
            rx_chan = (i == 0) ? 8'(ch) : 8'hEE;
            rx_nvalid = (i == ncyc - 1) ? 4'(words - 8 * (ncyc - 1)) : 4'd8;
            rx_eop_code = (i == ncyc - 1) ? (abort ? 4'b0001 : {1'b1, 3'(nbytes % 8)}) : 4'b0000;
            rx_err = (i == ncyc - 1) ? err : 1'b0;
        end
        @(negedge clk);
        idle_in();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset good_cnt", int'(good_cnt), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset last_bytes", int'(last_bytes), 0);

        // 179-byte packet on channel 2 with error flag
        send_pkt(2, 179, 1'b1, 1'b0);
        chk("R6 179 bytes", int'(last_bytes), 179);
        chk("R1 errored by flag", int'(last_good), 0);
        chk("R5 channel 2", int'(last_chan), 2);
        chk("R4 basic ignores rx_err", int'(last_good2), 1);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
        chk("R7 last_bytes held", int'(last_bytes), 179);
        @(negedge clk);
        // fresh good packet on channel 3
        send_pkt(3, 100, 1'b0, 1'b0);
        chk("R11 fresh bytes", int'(last_bytes), 100);
        chk("R11 fresh channel", int'(last_chan), 3);
        chk("R11 fresh verdict", int'(last_good), 1);
        // abort code classifies errored
        send_pkt(4, 17, 1'b0, 1'b1);
        chk("R1 abort code errored", int'(last_good), 0);

        // CRC24 during idle; rx_err during idle has no effect
        @(negedge clk); rx_err = 1;
        @(negedge clk); rx_err = 0;
        @(negedge clk);
        chk("R2 rx_err ignored", int'(crc_cnt), 0);
        crc24_err = 1;
        repeat (5) @(negedge clk);
        crc24_err = 0;
        @(negedge clk);
        chk("R3 idle crc count", int'(crc_cnt), 5);

        // CRC24 at end of packet: basic build marks errored
        @(negedge clk);
        rx_valid = 1; rx_sop_vec = 2'b10; rx_chan = 8'd9; rx_nvalid = 4'd2;
        rx_eop_code = 4'b1100; crc24_err = 1;
        @(negedge clk);
        idle_in(); crc24_err = 0;
        chk("R4 basic uses crc", int'(last_good2), 0);
        chk("R4 adv uses flag", int'(last_good), 1);
        chk("R6 single cycle bytes", int'(last_bytes), 12);

        // start inside an open packet
        @(negedge clk);
        rx_valid = 1; rx_sop_vec = 2'b10; rx_chan = 8'd7; rx_nvalid = 4'd8; rx_eop_code = 0;
        @(negedge clk);
        rx_sop_vec = 2'b10; rx_chan = 8'd5; rx_nvalid = 4'd1; rx_eop_code = 4'b1000;
        @(negedge clk);
        idle_in();
        chk("R8 restart flagged", int'(proto_err), 1);
        chk("R8 new packet channel", int'(last_chan), 5);
        chk("R8 new packet bytes", int'(last_bytes), 8);
        // end with nothing open
        rx_valid = 1; rx_nvalid = 4'd1; rx_eop_code = 4'b1000;
        @(negedge clk);
        idle_in();
        chk("R8 orphan end flagged", int'(proto_err), 1);
        chk("R8 orphan end no done", int'(done), 0);

        // saturation
        crc24_err = 1;
        repeat (MAX + 8) @(negedge clk);
        crc24_err = 0;
        @(negedge clk);
        chk("R9 crc saturates", int'(crc_cnt), MAX);
        for (int k = 0; k < MAX + 5; k++) send_pkt(1, 8, 1'b0, 1'b0);
        chk("R9 good saturates", int'(good_cnt), MAX);

        // clear beats increment
        @(negedge clk);
        clr = 1; crc24_err = 1;
        @(negedge clk);
        clr = 0; crc24_err = 0;
        chk("R10 clr good", int'(good_cnt), 0);
        chk("R10 clr crc", int'(crc_cnt), 0);
        chk("R10 clr err", int'(err_cnt), 0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule